// File: doc/BRIEF.md
# Vectored-Mask Interrupt Controller

The block collects interrupt events from 26 sources into a pending register and turns them into two active-low request lines for a small processor: a fast line and a normal line. A mask register decides which pending sources may request at all. A mode register sends each requesting source to either the fast line or the normal line. A three-bit control register carries two global enables. A source event is latched only while at least one of them is active.

Software reaches the block through a word-wide register bus. Writes take effect on the clock edge, and reads are combinational from the address. Software finds the source to service by reading an in-service word. This word is one-hot and names the lowest-numbered pending source. Software then acknowledges that source by writing a one to its bit on one of two clear ports. Four priority words are kept as plain read/write storage for software and do not change the arbitration.

Word addresses: 0 control, 1 mode, 2 pending (read only), 3 mask, 4 to 7 priority words A to D, 8 in-service (read only), 9 normal clear port, 10 fast clear port. Addresses 11 to 15 are unmapped.

Top module: `vmic_top`

## Requirements
- R1: After reset the control register reads 0x7, mode reads 0, pending reads 0, and mask reads 0x03FFFFFF (all 26 sources masked). Priority words A to D read 0x1B1B1B1B, 0x00001F1B, 0x1B1B1B1B and 0x0000001B. Both request outputs are high.
- R2: Control bit 1 at 0 enables normal requests, and control bit 0 at 0 enables fast requests. A pulse on `src_evt[i]` sets pending bit i on the next edge when either enable is active. When control bits 1 and 0 are both 1, events are ignored. The control register stores write data bits 2:0 and reads them zero-extended.
- R3: A source requests when its pending bit is 1 and its mask bit is 0. `fast_req_n` is low when some requesting source has mode bit 1. `norm_req_n` is low when some requesting source has mode bit 0. Both outputs are registered, so they reflect the pending, mask and mode values one clock edge later.
- R4: A read of address 8 returns a one-hot word with the lowest-numbered set pending bit, regardless of mask. If no bit is pending, the read returns 0.
- R5: A write to address 9 or address 10 clears every pending bit whose write-data bit is 1. Write-data bits 31:26 have no effect. Both addresses read as 0.
- R6: When a source event and a clear of the same bit fall on the same edge, the bit ends up set.
- R7: Writes to address 2 leave the pending register unchanged.
- R8: Priority words A to D at addresses 4 to 7 store and return all 32 bits.
- R9: Reads of addresses 11 to 15 return 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_evt | input | 26 | Per-source event pulses |
| fast_req_n | output | 1 | Fast interrupt request, active low |
| norm_req_n | output | 1 | Normal interrupt request, active low |

## Verification
On every cycle, the assertions check the following:
- Each request line follows the requesting sources of the previous edge, split by mode.
- An accepted event always lands in pending.
- No pending bit appears while both enables are off.
- A clear removes its bits unless an event sets them again.
- The in-service word is one-hot and non-zero exactly when something is pending.
- A write to the pending address changes nothing.

The bench scenarios cover the parts that depend on register decoding:
- reset contents of every word;
- the sweep of each source through both routing modes and both clear ports;
- lowest-first ordering as pending bits drain;
- the reads of unmapped and write-only addresses.

// File: rtl/vmic_pkg.sv
package vmic_pkg;
    localparam int unsigned NSRC_DEF = 26;
    localparam int unsigned DW_DEF   = 32;
    localparam int unsigned AW_DEF   = 4;
    localparam int unsigned NPRI     = 4;

    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_MODE  = 1;
    localparam int unsigned A_PEND  = 2;
    localparam int unsigned A_MASK  = 3;
    localparam int unsigned A_PRI0  = 4;
    localparam int unsigned A_INSRV = 8;
    localparam int unsigned A_CLRN  = 9;
    localparam int unsigned A_CLRF  = 10;

    localparam logic [2:0] CTRL_RST = 3'h7;

    function automatic logic [31:0] pri_reset(input int unsigned idx);
        logic [31:0] v;
        case (idx)
            0, 2:    v = 32'h1B1B1B1B;
            1:       v = 32'h00001F1B;
            default: v = 32'h0000001B;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/vmic_lowest_onehot.sv
module vmic_lowest_onehot #(
    parameter int unsigned W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign onehot[i]  = vec[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | vec[i];
    end

    assert_insrv_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onehot) && ((|onehot) == (|vec)));

    assert_insrv_member_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (onehot & ~vec) == '0);
endmodule

// File: rtl/vmic_pending.sv
module vmic_pending #(
    parameter int unsigned W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         latch_en,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] pend_q
);
    typedef struct packed {
        logic [W-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pend = st_d.pend & ~clr_bits;
        end
        if (latch_en) begin
            st_d.pend = st_d.pend | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;

    assert_event_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> ((pend_q & $past(evt)) == $past(evt)));

    assert_event_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> ((pend_q & ~$past(pend_q)) == '0));

    assert_clear_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (evt == '0)) |=> ((pend_q & $past(clr_bits)) == '0));
endmodule

// File: rtl/vmic_route.sv
module vmic_route #(
    parameter int unsigned W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] mode,
    output logic         fast_n,
    output logic         norm_n
);
    typedef struct packed {
        logic fast_n;
        logic norm_n;
    } route_st_t;

    route_st_t    st_d, st_q;
    logic [W-1:0] live;

    always_comb begin
        live        = pend & ~mask;
        st_d        = st_q;
        st_d.fast_n = ~|(live & mode);
        st_d.norm_n = ~|(live & ~mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fast_n = st_q.fast_n;
    assign norm_n = st_q.norm_n;

    assert_fast_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fast_n == ($past(pend & ~mask & mode) == '0)));

    assert_norm_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (norm_n == ($past(pend & ~mask & ~mode) == '0)));
endmodule

// File: rtl/vmic_top.sv
module vmic_top
    import vmic_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned DW   = DW_DEF,
    parameter int unsigned AW   = AW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_evt,
    output logic            fast_req_n,
    output logic            norm_req_n
);
    localparam int unsigned PADW = DW - NSRC;

    typedef struct packed {
        logic [2:0]                ctrl;
        logic [NSRC-1:0]           mode;
        logic [NSRC-1:0]           mask;
        logic [NPRI-1:0][DW-1:0]   pri;
    } regs_t;

    regs_t           rg_d, rg_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] insrv;
    logic            latch_en;
    logic            clr_en;

    assign latch_en = ~rg_q.ctrl[1] | ~rg_q.ctrl[0];
    assign clr_en   = bus_we && ((bus_addr == AW'(A_CLRN)) || (bus_addr == AW'(A_CLRF)));

    always_comb begin
        rg_d = rg_q;
        if (bus_we) begin
            if (bus_addr == AW'(A_CTRL)) rg_d.ctrl = bus_wdata[2:0];
            if (bus_addr == AW'(A_MODE)) rg_d.mode = bus_wdata[NSRC-1:0];
            if (bus_addr == AW'(A_MASK)) rg_d.mask = bus_wdata[NSRC-1:0];
            for (int p = 0; p < NPRI; p++) begin
                if (bus_addr == AW'(A_PRI0 + p)) rg_d.pri[p] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.ctrl <= CTRL_RST;
            rg_q.mode <= '0;
            rg_q.mask <= '1;
            for (int p = 0; p < NPRI; p++) begin
                rg_q.pri[p] <= pri_reset(p);
            end
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '1;
        case (bus_addr)
            AW'(A_CTRL):  bus_rdata = {{(DW-3){1'b0}}, rg_q.ctrl};
            AW'(A_MODE):  bus_rdata = {{PADW{1'b0}}, rg_q.mode};
            AW'(A_PEND):  bus_rdata = {{PADW{1'b0}}, pend_q};
            AW'(A_MASK):  bus_rdata = {{PADW{1'b0}}, rg_q.mask};
            AW'(A_PRI0):  bus_rdata = rg_q.pri[0];
            AW'(A_PRI0+1): bus_rdata = rg_q.pri[1];
            AW'(A_PRI0+2): bus_rdata = rg_q.pri[2];
            AW'(A_PRI0+3): bus_rdata = rg_q.pri[3];
            AW'(A_INSRV): bus_rdata = {{PADW{1'b0}}, insrv};
            AW'(A_CLRN):  bus_rdata = '0;
            AW'(A_CLRF):  bus_rdata = '0;
            default:      bus_rdata = '1;
        endcase
    end

    vmic_pending #(.W(NSRC)) i_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .latch_en (latch_en),
        .clr_en   (clr_en),
        .clr_bits (bus_wdata[NSRC-1:0]),
        .pend_q   (pend_q)
    );

    vmic_lowest_onehot #(.W(NSRC)) i_lowest (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec    (pend_q),
        .onehot (insrv)
    );

    vmic_route #(.W(NSRC)) i_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_q),
        .mask   (rg_q.mask),
        .mode   (rg_q.mode),
        .fast_n (fast_req_n),
        .norm_n (norm_req_n)
    );

    assert_pend_not_writable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == AW'(A_PEND)) && (src_evt == '0)) |=> $stable(pend_q));
endmodule

// File: tb/test_vmic_top.sv
module test_vmic_top;
    localparam int N = 26;
    localparam logic [31:0] ALL = 32'h03FFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] src_evt = '0;
    logic        fast_req_n, norm_req_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vmic_top i_vmic_top (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .fast_req_n(fast_req_n), .norm_req_n(norm_req_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    function automatic logic [31:0] lowest(input logic [31:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return 32'(1) << i;
        return 32'h0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] modev;
        logic [31:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        rd(0, r); chk("R1 ctrl", r, 32'h7);
        rd(1, r); chk("R1 mode", r, 32'h0);
        rd(2, r); chk("R1 pend", r, 32'h0);
        rd(3, r); chk("R1 mask", r, ALL);
        rd(4, r); chk("R1 priA", r, 32'h1B1B1B1B);
        rd(5, r); chk("R1 priB", r, 32'h00001F1B);
        rd(6, r); chk("R1 priC", r, 32'h1B1B1B1B);
        rd(7, r); chk("R1 priD", r, 32'h0000001B);
        chk("R1 outputs", {30'b0, fast_req_n, norm_req_n}, 32'h3);

        // R8 priority storage
        for (int k = 0; k < 4; k++) begin
            wr(4 + k, 32'hA5000000 ^ (32'h01010101 * (k + 1)));
            rd(4 + k, r); chk("R8 pri", r, 32'hA5000000 ^ (32'h01010101 * (k + 1)));
        end

        // R9 unmapped, R5 clear ports read zero
        for (int a = 11; a < 16; a++) begin
            rd(a, r); chk("R9 unmapped", r, 32'hFFFFFFFF);
        end
        rd(9, r); chk("R5 clrn read", r, 32'h0);
        rd(10, r); chk("R5 clrf read", r, 32'h0);

        // R2 both enables off: events ignored
        pulse('1);
        rd(2, r); chk("R2 ignored", r, 32'h0);

        wr(0, 32'hFFFFFFFC);
        rd(0, r); chk("R2 ctrl width", r, 32'h4);
        wr(3, 32'h0);

        // R3/R4/R5 sweep each source in both modes
        for (int pass = 0; pass < 2; pass++) begin
            modev = (pass == 0) ? 32'h02AAAAAA : 32'h01555555;
            wr(1, modev);
            for (int i = 0; i < N; i++) begin
                pulse(N'(1) << i);
                rd(2, r); chk("R2 latch", r, 32'(1) << i);
                rd(8, r); chk("R4 insrv", r, 32'(1) << i);
                chk("R3 latency", {30'b0, fast_req_n, norm_req_n}, 32'h3);
                @(negedge clk);
                chk("R3 route", {30'b0, fast_req_n, norm_req_n},
                    modev[i] ? 32'h1 : 32'h2);
                wr((i % 2 == 0) ? 9 : 10, 32'(1) << i);
                rd(2, r); chk("R5 clear", r, 32'h0);
                @(negedge clk);
                chk("R3 release", {30'b0, fast_req_n, norm_req_n}, 32'h3);
            end
        end

        // R4 ordering as pending drains
        pulse('1);
        p = ALL;
        for (int k = 0; k < N; k++) begin
            rd(8, r); chk("R4 lowest", r, lowest(p));
            wr(9 + (k % 2), 32'(1) << k);
            p = p & ~(32'(1) << k);
        end
        rd(8, r); chk("R4 empty", r, 32'h0);

        // R2 single enable variants
        wr(0, 32'h5); pulse(N'(1) << 7); rd(2, r); chk("R2 normal en", r, 32'h80);
        wr(0, 32'h6); pulse(N'(1) << 9); rd(2, r); chk("R2 fast en", r, 32'h280);
        wr(0, 32'h7); pulse(N'(1) << 11); rd(2, r); chk("R2 both off", r, 32'h280);
        wr(0, 32'h4);

        // R7 pending not writable
        wr(2, 32'hFFFFFFFF); rd(2, r); chk("R7 write pend", r, 32'h280);
        wr(2, 32'h0); rd(2, r); chk("R7 write pend zero", r, 32'h280);

        // R5 upper bits ignored
        wr(9, 32'hFC000000); rd(2, r); chk("R5 upper bits", r, 32'h280);

        // R3 masked pending does not request
        wr(3, 32'h280);
        @(negedge clk);
        chk("R3 masked", {30'b0, fast_req_n, norm_req_n}, 32'h3);
        wr(3, 32'h0);
        wr(9, 32'h280);

        // R6 set wins over clear on the same edge, other bit still clears
        pulse(N'(1) << 5);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(9); bus_wdata = 32'h28; src_evt = N'(1) << 3;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; src_evt = '0;
        rd(2, r); chk("R6 set wins", r, 32'h8);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule